// File: doc/BRIEF.md
# Real-Time Clock Core with Shadowed Always-On Registers

This block is a memory-mapped real-time clock core with a 32-bit register file. Software writes to the seconds counter, the alarm compare value and the two persistent configuration words land in bus-side shadow copies. A background updater then moves them one at a time into the always-on copies that the clock logic uses. While a shadow copy waits for its turn, a stale flag for that register is visible in the status word. Software polls that flag before it trusts a read. Reads of these registers return the always-on value, not the shadow.

The seconds counter advances once per second. The one-second pulse comes from a prescaler that counts pulses on a crystal-rate enable input. A configuration bit picks a divide ratio for either a 32000 Hz or a 32768 Hz crystal. When the counter reaches the alarm value and the alarm is enabled, the core sets a sticky flag in the control word. It may also set a wake-status bit. The interrupt output is that flag gated by an enable bit. Each register decodes three access forms that differ in address bits [3:2]: a plain write, a set alias (OR in the ones) and a clear alias (AND out the ones). These let software change single bits without a read-modify-write.

Top module: `rtc_shadow_core`

## Requirements
- R1: After reset every register reads zero, the stale field is zero, `alarm_irq` is low, and the status word (offset 0x10) reads bit 31 as one. Status bit 28 equals the `HAS_XTAL_32000` parameter and bit 27 equals the `HAS_XTAL_32768` parameter.
- R2: Each register sits on a 16-byte boundary. Address bits [3:2] select the access: 00 is a plain write, 01 ORs the data in, 10 clears the bits that are one in the data, and 11 does nothing. The control word (0x00) and the watchdog word (0x50) take writes at once. In the control word only bits 0 (alarm interrupt enable), 1 (millisecond interrupt enable), 2 (alarm flag) and 4 (watchdog enable) are stored; all other bits read zero.
- R3: A write to a shadowed register sets that register's stale bit in the same cycle. Until the commit, a read returns the previous always-on value. Stale bit positions in status bits [23:16] are: persistent0 = 16, persistent1 = 17, alarm = 22, seconds = 23. Bits 18..21 always read zero.
- R4: The updater visits eight slots in a fixed order: persistent0, persistent1, four unused slots, alarm, seconds. Each slot lasts `SLOT_CYCLES` cycles. A stale register commits and clears its stale bit at the end of its slot. A pass begins one cycle after a stale bit appears on an idle updater, so the seconds stale bit clears within 8*`SLOT_CYCLES`+1 cycles of the write.
- R5: The set and clear aliases act on shadowed registers (seconds 0x30, alarm 0x40, persistent0 0x60, persistent1 0x70) in the same way, through the shadow copy.
- R6: Each `xtal_en` high cycle counts toward the next second. The seconds count increments once every `DIV_32768` such cycles when persistent0 bit 6 is 0, and once every `DIV_32000` such cycles when it is 1. With `xtal_en` low the count holds.
- R7: A committed seconds write replaces the running count. A tick in the commit cycle is lost.
- R8: When the seconds count becomes equal to the alarm value while persistent0 bit 2 (alarm enable) is one, control bit 2 sets one cycle later. `alarm_irq` is control bit 2 AND control bit 0. With alarm enable zero, reaching the alarm value sets nothing.
- R9: If persistent0 bit 1 (wake enable) is also one at that event, persistent0 bit 7 (wake status) sets as well.
- R10: Writing bit 2 to the control clear alias (0x08) clears the alarm flag and drops `alarm_irq`. The flag stays clear while the count remains equal to the alarm value.
- R11: Writing persistent1 with bit 31 set marks persistent0, persistent1 and alarm stale, which forces a pass. Bit 31 is not stored and reads zero.
- R12: Writes to the status word and to unmapped offsets have no effect; unmapped offsets and misaligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_en | input | 1 | One pulse per crystal period, feeds the prescaler |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address: register in [7:4], access form in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
A vector table drives plain, set and clear accesses into the two immediate registers and into an unmapped offset. This separates the three access forms and shows the control-word bit mask. Directed sequences write seconds and persistent0 one cycle apart and poll the stale field every cycle. This shows that the earlier slot commits first, even though its write came later, and that stale reads return the old value. The counter is run with `xtal_en` held high for exact multiples of both divide ratios, and held low, which tells the two ratios apart. The alarm is then driven with the enable set and with it cleared, and the flag is cleared while the count still matches. This tells an edge-triggered flag from a level-triggered one.

// File: rtl/rtcs_pkg.sv
// Package: shared constants, access kinds and the alias helper for the RTC core.
// Assumes byte addresses with the register index in [7:4] and access kind in [3:2].
package rtcs_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_SLOTS = 8;

    // Register index = address bits [7:4]
    localparam logic [3:0] IDX_CTRL  = 4'h0;
    localparam logic [3:0] IDX_STAT  = 4'h1;
    localparam logic [3:0] IDX_SECS  = 4'h3;
    localparam logic [3:0] IDX_ALRM  = 4'h4;
    localparam logic [3:0] IDX_WDOG  = 4'h5;
    localparam logic [3:0] IDX_PERS0 = 4'h6;
    localparam logic [3:0] IDX_PERS1 = 4'h7;

    // Updater slot numbers; the order is the commit order
    localparam int SLOT_PERS0 = 0;
    localparam int SLOT_PERS1 = 1;
    localparam int SLOT_ALRM  = 6;
    localparam int SLOT_SECS  = 7;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0017;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'b00,
        ACC_SET   = 2'b01,
        ACC_CLR   = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_t;

    // Resolve a plain / set / clear access against the current value
    function automatic logic [DATA_W-1:0] apply_acc(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] wd,
                                                    input acc_kind_t kind);
        case (kind)
            ACC_WRITE: apply_acc = wd;
            ACC_SET:   apply_acc = cur | wd;
            ACC_CLR:   apply_acc = cur & ~wd;
            default:   apply_acc = cur;
        endcase
    endfunction

endpackage

// File: rtl/rtcs_prescaler.sv
// Module: divides the crystal-rate enable into a one-second tick.
// Assumes xtal_en is a single-cycle pulse per crystal period; sel_32000 picks the ratio.
module rtcs_prescaler #(
    parameter int DIV_32768 = 32768,
    parameter int DIV_32000 = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_en,
    input  logic sel_32000,
    output logic tick
);
    localparam int DMAX = (DIV_32768 > DIV_32000) ? DIV_32768 : DIV_32000;
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    // Terminal-count detect; >= keeps the divider safe when the ratio changes
    always_comb begin
        if (sel_32000) at_end = (cnt_q >= CW'(DIV_32000 - 1));
        else           at_end = (cnt_q >= CW'(DIV_32768 - 1));
        tick = xtal_en && at_end;
    end

    // Count enable pulses and wrap on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else if (xtal_en)  cnt_q <= cnt_q + 1'b1;
    end

    p_tick_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/rtcs_updater.sv
// Module: serial shadow-to-always-on updater walking a fixed slot order.
// Assumes stale stays set until its commit pulse; spends SLOT_CYCLES per slot.
module rtcs_updater #(
    parameter int NUM_SLOTS   = 8,
    parameter int SLOT_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] stale,
    output logic [NUM_SLOTS-1:0] commit,
    output logic                 busy
);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int CW = $clog2(SLOT_CYCLES + 1);

    logic [SW-1:0] slot_q;
    logic [CW-1:0] cnt_q;
    logic          slot_end;

    assign slot_end = busy && (cnt_q == CW'(SLOT_CYCLES - 1));

    // Sequence: start a pass on any stale bit, step slots in order, stop after the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            slot_q <= '0;
            cnt_q  <= '0;
        end else if (!busy) begin
            if (|stale) begin
                busy   <= 1'b1;
                slot_q <= '0;
                cnt_q  <= '0;
            end
        end else if (slot_end) begin
            cnt_q <= '0;
            if (slot_q == SW'(NUM_SLOTS - 1)) busy   <= 1'b0;
            else                              slot_q <= slot_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Commit pulse per slot, only for registers that are actually stale
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_commit
        assign commit[k] = slot_end && (slot_q == SW'(k)) && stale[k];
    end

    p_one_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit));

    p_slot_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/rtcs_alarm.sv
// Module: detects the cycle in which seconds becomes equal to the alarm value.
// Assumes the caller makes the flag sticky; emits a single-cycle pulse per match.
module rtcs_alarm #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] seconds,
    input  logic [DW-1:0] alarm,
    input  logic          enable,
    output logic          hit
);
    logic match, match_q;

    assign match = (seconds == alarm);
    assign hit   = enable && match && !match_q;

    // Remember the previous compare result for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    p_hit_is_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/rtc_shadow_core.sv
// Module: RTC core top: register decode, shadow and always-on copies, seconds, alarm.
// Assumes single-cycle bus writes and combinational reads; one synchronous reset.
module rtc_shadow_core
    import rtcs_pkg::*;
#(
    parameter int DIV_32768      = 32768,
    parameter int DIV_32000      = 32000,
    parameter int SLOT_CYCLES    = 16,
    parameter bit HAS_XTAL_32000 = 1'b0,
    parameter bit HAS_XTAL_32768 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    logic [3:0]  idx;
    acc_kind_t   acc;
    logic        wr_ok;
    logic        wr_ctrl, wr_wdog, wr_p0, wr_p1, wr_alrm, wr_secs;
    logic [DATA_W-1:0] ctrl_q, wdog_q;
    logic [DATA_W-1:0] sh_p0, sh_p1, sh_alrm, sh_secs;
    logic [DATA_W-1:0] p0_q, p1_q, alrm_q, secs_q;
    logic [DATA_W-1:0] p1_next;
    logic [NUM_SLOTS-1:0] stale_q, commit;
    logic        force_pass, tick, hit, upd_busy;

    // Address decode
    always_comb begin
        idx     = bus_addr[7:4];
        acc     = acc_kind_t'(bus_addr[3:2]);
        wr_ok   = bus_we && (acc != ACC_NONE) && (bus_addr[1:0] == 2'b00);
        wr_ctrl = wr_ok && (idx == IDX_CTRL);
        wr_wdog = wr_ok && (idx == IDX_WDOG);
        wr_p0   = wr_ok && (idx == IDX_PERS0);
        wr_p1   = wr_ok && (idx == IDX_PERS1);
        wr_alrm = wr_ok && (idx == IDX_ALRM);
        wr_secs = wr_ok && (idx == IDX_SECS);
        p1_next    = apply_acc(sh_p1, bus_wdata, acc);
        force_pass = wr_p1 && p1_next[DATA_W-1];
    end

    rtcs_prescaler #(.DIV_32768(DIV_32768), .DIV_32000(DIV_32000)) u_presc (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .sel_32000(p0_q[6]), .tick(tick));

    rtcs_updater #(.NUM_SLOTS(NUM_SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) u_upd (
        .clk(clk), .rst_n(rst_n), .stale(stale_q), .commit(commit), .busy(upd_busy));

    rtcs_alarm #(.DW(DATA_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .seconds(secs_q), .alarm(alrm_q),
        .enable(p0_q[2]), .hit(hit));

    // Immediate registers: control (alarm flag set wins over clear) and watchdog
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wdog_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= apply_acc(ctrl_q, bus_wdata, acc) & CTRL_MASK;
            if (hit)     ctrl_q[2] <= 1'b1;
            if (wr_wdog) wdog_q <= apply_acc(wdog_q, bus_wdata, acc);
        end
    end

    // Shadow copies take bus writes; wake status is mirrored so a commit keeps it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_p0 <= '0; sh_p1 <= '0; sh_alrm <= '0; sh_secs <= '0;
        end else begin
            if (wr_p0)   sh_p0   <= apply_acc(sh_p0, bus_wdata, acc);
            if (hit && p0_q[1]) sh_p0[7] <= 1'b1;
            if (wr_p1)   sh_p1   <= {1'b0, p1_next[DATA_W-2:0]};
            if (wr_alrm) sh_alrm <= apply_acc(sh_alrm, bus_wdata, acc);
            if (wr_secs) sh_secs <= apply_acc(sh_secs, bus_wdata, acc);
        end
    end

    // Stale flags: a write or forced pass sets, the matching commit clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale_q <= '0;
        end else begin
            stale_q <= stale_q & ~commit;
            if (wr_p0 || force_pass)   stale_q[SLOT_PERS0] <= 1'b1;
            if (wr_p1)                 stale_q[SLOT_PERS1] <= 1'b1;
            if (wr_alrm || force_pass) stale_q[SLOT_ALRM]  <= 1'b1;
            if (wr_secs)               stale_q[SLOT_SECS]  <= 1'b1;
        end
    end

    // Always-on copies: commits from the updater, seconds ticking, wake status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_q <= '0; p1_q <= '0; alrm_q <= '0; secs_q <= '0;
        end else begin
            if (commit[SLOT_PERS0]) p0_q   <= sh_p0;
            if (hit && p0_q[1])     p0_q[7] <= 1'b1;
            if (commit[SLOT_PERS1]) p1_q   <= sh_p1;
            if (commit[SLOT_ALRM])  alrm_q <= sh_alrm;
            if (commit[SLOT_SECS])  secs_q <= sh_secs;
            else if (tick)          secs_q <= secs_q + 1'b1;
        end
    end

    // Read mux: always-on values, status built from presence bits and stale field
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[3:0] == 4'h0) begin
            case (idx)
                IDX_CTRL:  bus_rdata = ctrl_q;
                IDX_STAT:  bus_rdata = {1'b1, 2'b00, HAS_XTAL_32000, HAS_XTAL_32768,
                                        3'b000, stale_q, 16'h0000};
                IDX_SECS:  bus_rdata = secs_q;
                IDX_ALRM:  bus_rdata = alrm_q;
                IDX_WDOG:  bus_rdata = wdog_q;
                IDX_PERS0: bus_rdata = p0_q;
                IDX_PERS1: bus_rdata = p1_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign alarm_irq = ctrl_q[2] && ctrl_q[0];

    p_secs_clear_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stale_q[SLOT_SECS]) |-> $past(commit[SLOT_SECS]));

    p_secs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !commit[SLOT_SECS]) |=> (secs_q == $past(secs_q) + 1'b1));

    p_secs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit[SLOT_SECS] |=> (secs_q == $past(sh_secs)));

    p_flag_from_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q[2]) && !$past(wr_ctrl)) |-> $past(secs_q == alrm_q && p0_q[2]));

    p_stale_bits_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stale_q[5:2] == 4'b0000);

    p_pass_when_stale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(|stale_q) && $past(!upd_busy)) |-> upd_busy);

endmodule

// File: tb/rtc_shadow_core_tb.sv
module rtc_shadow_core_tb;
    localparam int DA = 6;   // ratio when persistent0 bit 6 = 0
    localparam int DB = 5;   // ratio when persistent0 bit 6 = 1
    localparam int SC = 4;
    localparam logic [31:0] STAT_BASE = 32'h9000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rtc_shadow_core #(.DIV_32768(DA), .DIV_32000(DB), .SLOT_CYCLES(SC),
                      .HAS_XTAL_32000(1'b1), .HAS_XTAL_32768(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq));

    // Vector table: access address, data, expected readback at the register base
    localparam logic [7:0]  T_ADDR [8] = '{8'h00, 8'h08, 8'h04, 8'h00, 8'h50, 8'h54, 8'h58, 8'h20};
    localparam logic [31:0] T_DATA [8] = '{32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0001, 32'h0,
                                           32'h1234_5678, 32'h0000_0F00, 32'h1000_0000, 32'hFFFF};
    localparam logic [31:0] T_EXP  [8] = '{32'h17, 32'h12, 32'h13, 32'h0,
                                           32'h1234_5678, 32'h1234_5F78, 32'h0234_5F78, 32'h0};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            brd(8'h10, s);
            if (s[23:16] == 8'h00) break;
        end
    endtask

    task automatic run_xtal(input int n);
        @(negedge clk);
        xtal_en = 1'b1;
        repeat (n) @(negedge clk);
        xtal_en = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        int t_p0, t_sec;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(8'h10, r); chk("R1 stat", r, STAT_BASE);
        brd(8'h00, r); chk("R1 ctrl", r, 32'h0);
        brd(8'h30, r); chk("R1 seconds", r, 32'h0);
        brd(8'h60, r); chk("R1 pers0", r, 32'h0);
        chk("R1 irq", {31'b0, alarm_irq}, 32'h0);

        // R2 table walk over immediate registers and an unmapped slot (R12)
        for (int i = 0; i < 8; i++) begin
            bwr(T_ADDR[i], T_DATA[i]);
            brd({T_ADDR[i][7:4], 4'h0}, r);
            chk("R2/R12 table", r, T_EXP[i]);
        end
        bwr(8'h10, 32'hFFFF_FFFF);
        brd(8'h10, r); chk("R12 stat ignores write", r, STAT_BASE);
        bwr(8'h0C, 32'h1);
        brd(8'h00, r); chk("R2 alias 11 no effect", r, 32'h0);
        brd(8'h04, r); chk("R12 misaligned reads zero", r, 32'h0);

        // R3/R4 ordering: seconds written before persistent0, persistent0 commits first
        bwr(8'h30, 32'd100);
        brd(8'h10, r); chk("R3 seconds stale at once", r, STAT_BASE | 32'h0080_0000);
        brd(8'h30, r); chk("R3 old value while stale", r, 32'h0);
        bwr(8'h64, 32'h0000_0040);               // R5 set alias on shadow
        t_p0 = -1; t_sec = -1;
        for (int i = 1; i < 60; i++) begin
            brd(8'h10, r);
            if (t_p0 < 0 && !r[16]) t_p0 = i;
            if (t_sec < 0 && !r[23]) t_sec = i;
            @(negedge clk);
        end
        chk("R4 pers0 before seconds", {31'b0, (t_p0 > 0 && t_p0 < t_sec)}, 32'h1);
        chk("R4 pass bound", {31'b0, (t_sec > 0 && t_sec <= 8*SC + 1)}, 32'h1);
        brd(8'h30, r); chk("R7 seconds committed", r, 32'd100);
        brd(8'h60, r); chk("R5 pers0 set alias", r, 32'h40);

        // R6 count with ratio DB (bit6 = 1), hold with xtal_en low, then ratio DA
        run_xtal(3*DB);
        brd(8'h30, r); chk("R6 ratio 32000", r, 32'd103);
        repeat (10) @(negedge clk);
        brd(8'h30, r); chk("R6 hold when idle", r, 32'd103);
        bwr(8'h68, 32'h0000_0040);               // R5 clear alias
        wait_idle();
        brd(8'h60, r); chk("R5 pers0 clear alias", r, 32'h0);
        run_xtal(3*DA);
        brd(8'h30, r); chk("R6 ratio 32768", r, 32'd106);

        // R8/R9 alarm with enable and wake enable
        bwr(8'h64, 32'h0000_0046);
        bwr(8'h40, 32'd202);
        bwr(8'h30, 32'd200);
        bwr(8'h04, 32'h1);
        wait_idle();
        chk("R8 no irq before match", {31'b0, alarm_irq}, 32'h0);
        run_xtal(2*DB);
        repeat (2) @(negedge clk);
        brd(8'h30, r); chk("R8 seconds at alarm", r, 32'd202);
        brd(8'h00, r); chk("R8 flag set", r, 32'h5);
        chk("R8 irq high", {31'b0, alarm_irq}, 32'h1);
        brd(8'h60, r); chk("R9 wake status", r, 32'hC6);

        // R10 clear flag while count still equals alarm
        bwr(8'h08, 32'h4);
        repeat (3) @(negedge clk);
        brd(8'h00, r); chk("R10 flag cleared", r, 32'h1);
        chk("R10 irq low", {31'b0, alarm_irq}, 32'h0);

        // R8 negative: alarm enable off, match reached, nothing sets
        bwr(8'h68, 32'h0000_0084);
        bwr(8'h40, 32'd205);
        wait_idle();
        brd(8'h60, r); chk("R5 pers0 cleared bits", r, 32'h42);
        run_xtal(3*DB);
        repeat (2) @(negedge clk);
        brd(8'h30, r); chk("R8 seconds at 205", r, 32'd205);
        brd(8'h00, r); chk("R8 no flag when disabled", r, 32'h1);
        chk("R8 irq stays low", {31'b0, alarm_irq}, 32'h0);

        // R11 forced pass through persistent1 bit 31
        bwr(8'h74, 32'h8000_0001);
        brd(8'h10, r); chk("R11 forced stale set", r, STAT_BASE | 32'h0043_0000);
        wait_idle();
        brd(8'h70, r); chk("R11 bit31 not stored", r, 32'h1);
        brd(8'h40, r); chk("R11 alarm unchanged", r, 32'd205);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule